// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is a cycle-level model of a single-ported synchronous SRAM with one shared data bus and a flow-through read path. Two address strobes can open an access. One is meant for a processor and one for a memory controller, and they sample the write controls at different times. Three chip enables qualify an access. Writes are selected with a global write, or with a byte-write enable plus one active-low select per byte. An output enable and a burst step input complete the controls. Each read or write lands on an internal word array. The data bus is modelled as a separate input word, output word and drive-enable bit.

The block registers a base address and a burst count. After an access opens, each later rising edge with no strobe continues the access. If the step input is low at that edge, the access moves to the next burst address. A separate generator computes that address in either linear or interleaved order. A sleep request from another clock domain drops any open access. While asleep, no access can start and the array keeps its contents. After the request is released, strobes are refused for a fixed recovery interval.

Top module: `sync_burst_sram`

## Requirements
- R1: An access opens at a rising edge when a strobe is taken and all three enables are active: `en1_n` low, `en2` high, `en3_n` low. If no byte is selected for writing, it opens as a read. From that edge on, in the same cycle, `dq_o` carries the word at the registered address and `dq_oe` is 1 while `out_en_n` is low.
- R2: The processor strobe `pstb_n` is ignored while `en1_n` is high. The current access then continues as if no strobe were present.
- R3: At the edge where the processor strobe is taken, the write controls and `step_n` are ignored, and the access opens as a read at the burst start. The next edge decides between write and read, and a write stores `dq_i` as sampled at that edge.
- R4: The controller strobe `cstb_n` writes at its own edge when `pstb_n` is high, the enables are active and at least one byte is selected. The data is `dq_i` at that edge. `cstb_n` is ignored whenever `pstb_n` is low.
- R5: Byte selection follows a fixed priority. With `wr_all_n` low, all four bytes are selected. Otherwise, with `wr_byte_n` low, byte i (bits 8i+7..8i) is selected when `byte_sel_n[i]` is 0. Otherwise no byte is selected. Bytes that are not selected keep their old value.
- R6: `dq_oe` is 0 whenever any byte is selected at the inputs, whatever `out_en_n` is. It is also 0 during the cycle after a write edge.
- R7: `dq_oe` is 0 whenever `out_en_n` is high.
- R8: At an edge that continues an access with `step_n` low, the burst count advances by one. Only the two low address bits change. With `burst_linear` = 1 they read (start + n) mod 4; with `burst_linear` = 0 they read start XOR n.
- R9: At an edge that continues an access with `step_n` high, the address stays the same. At every continuing edge, a selected byte makes it a write and no selection makes it a read.
- R10: A strobe that is taken while the enables are not all active deselects the block. `dq_oe` then stays 0 and later continuing edges are ignored. After reset, `dq_oe` is 0.
- R11: `sleep_req` passes through two flops. The cycle after the first edge still behaves normally. From the second edge on, the bus is released and the open access is dropped. Every edge after that refuses strobes. The stored words are kept.
- R12: After `sleep_req` falls, strobes are refused at the first two edges. They are refused at the next `RECOV_CYC` edges as well. The edge after that accepts them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address captured when a strobe is taken |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| en1_n | input | 1 | Primary enable, active low |
| en2 | input | 1 | Second enable, active high |
| en3_n | input | 1 | Third enable, active low |
| wr_all_n | input | 1 | Write every byte, active low |
| wr_byte_n | input | 1 | Write only the selected bytes, active low |
| byte_sel_n | input | NB | Byte selects, active low |
| out_en_n | input | 1 | Output enable, active low |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| dq_i | input | NB*8 | Write data taken from the bus |
| dq_o | output | NB*8 | Read data, zero when the bus is not driven |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Read data and the bus enable are combinational from the registered access and the present inputs. Each cycle's expected bus value is therefore known from the edge just before it. A write shows up the first time a later edge opens a read at that address. Entering sleep takes effect two edges after the request. Leaving sleep frees the strobes only `RECOV_CYC + 2` edges after the release, and the bench places its first access exactly at that edge. Inputs change on the falling edge, and a behavioural model predicts the bus. The bench compares against that prediction 2 ns before every rising edge, so each result is checked in the cycle where it is due.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

    // Kind of access that is open between two rising edges
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

endpackage

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
// Maps a burst start offset and a step count to the low address bits.
module burst_addr_gen #(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] start_off,
    input  logic [BURST_BITS-1:0] step_cnt,
    input  logic                  linear,
    output logic [BURST_BITS-1:0] offs
);

    logic [BURST_BITS-1:0] lin_offs;
    logic [BURST_BITS-1:0] ilv_offs;

    // Linear order wraps inside the burst; interleaved order toggles bits
    assign lin_offs = start_off + step_cnt;
    assign ilv_offs = start_off ^ step_cnt;
    assign offs     = linear ? lin_offs : ilv_offs;

endmodule

// File: rtl/sleep_ctrl.sv
`timescale 1ns/1ps
// Synchronises the sleep request and times the recovery interval.
module sleep_ctrl #(
    parameter int RECOV_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic asleep,
    output logic recovering
);

    localparam int RW = $clog2(RECOV_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [RW-1:0] rc;
    } slp_t;

    slp_t slp_d, slp_q;

    always_comb begin
        slp_d    = slp_q;
        slp_d.s1 = sleep_req;
        slp_d.s2 = slp_q.s1;
        if (slp_q.s2 && !slp_q.s1) begin
            slp_d.rc = RW'(RECOV_CYC);
        end else if (slp_q.rc != '0) begin
            slp_d.rc = slp_q.rc - RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slp_q <= '0;
        end else begin
            slp_q <= slp_d;
        end
    end

    assign asleep     = slp_q.s2;
    assign recovering = (slp_q.rc != '0);

endmodule

// File: rtl/sram_core.sv
`timescale 1ns/1ps
// Word array with per-byte write lanes and an unregistered read port.
module sram_core #(
    parameter int AW     = 8,
    parameter int NB     = 4,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [NB-1:0]        wmask,
    input  logic [AW-1:0]        waddr,
    input  logic [NB*BYTE_W-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic [NB*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[b]) begin
                lane[waddr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane[raddr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sbsram_pkg::*;
#(
    parameter int AW         = 8,
    parameter int NB         = 4,
    parameter int BURST_BITS = 2,
    parameter int RECOV_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              step_n,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [NB-1:0]     byte_sel_n,
    input  logic              out_en_n,
    input  logic              burst_linear,
    input  logic              sleep_req,
    input  logic [NB*8-1:0]   dq_i,
    output logic [NB*8-1:0]   dq_o,
    output logic              dq_oe
);

    localparam int BYTE_W = 8;
    localparam int DW     = NB * BYTE_W;
    localparam int HI_W   = AW - BURST_BITS;

    typedef struct packed {
        acc_e                  st;
        logic [AW-1:0]         base;
        logic [BURST_BITS-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  asleep;
    logic                  recovering;
    logic                  blocked;
    logic                  chip_sel;
    logic                  pstb_take;
    logic                  cstb_take;
    logic [NB-1:0]         wmask;
    logic                  wr_req;
    logic [BURST_BITS-1:0] step_cnt;
    logic [BURST_BITS-1:0] off_cur;
    logic [BURST_BITS-1:0] off_next;
    logic [AW-1:0]         cur_addr;
    logic [AW-1:0]         cont_addr;
    logic                  mem_we;
    logic [AW-1:0]         mem_waddr;
    logic [DW-1:0]         rdata;
    acc_e                  st_q;

    // ---------------- sleep handling ----------------
    sleep_ctrl #(
        .RECOV_CYC (RECOV_CYC)
    ) u_sleep (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .asleep     (asleep),
        .recovering (recovering)
    );

    assign blocked = asleep | recovering;

    // ---------------- input decode ----------------
    assign chip_sel  = !en1_n && en2 && !en3_n;
    assign pstb_take = !pstb_n && !en1_n;
    assign cstb_take = pstb_n && !cstb_n;

    always_comb begin
        if (!wr_all_n) begin
            wmask = '1;
        end else if (!wr_byte_n) begin
            wmask = ~byte_sel_n;
        end else begin
            wmask = '0;
        end
    end

    assign wr_req = |wmask;

    // ---------------- burst addressing ----------------
    assign step_cnt = step_n ? ctl_q.cnt : ctl_q.cnt + BURST_BITS'(1);

    burst_addr_gen #(
        .BURST_BITS (BURST_BITS)
    ) u_gen_cur (
        .start_off (ctl_q.base[BURST_BITS-1:0]),
        .step_cnt  (ctl_q.cnt),
        .linear    (burst_linear),
        .offs      (off_cur)
    );

    burst_addr_gen #(
        .BURST_BITS (BURST_BITS)
    ) u_gen_next (
        .start_off (ctl_q.base[BURST_BITS-1:0]),
        .step_cnt  (step_cnt),
        .linear    (burst_linear),
        .offs      (off_next)
    );

    assign cur_addr  = {ctl_q.base[AW-1:AW-HI_W], off_cur};
    assign cont_addr = {ctl_q.base[AW-1:AW-HI_W], off_next};

    // ---------------- access control ----------------
    always_comb begin
        ctl_d     = ctl_q;
        mem_we    = 1'b0;
        mem_waddr = cur_addr;
        if (blocked) begin
            ctl_d.st = ACC_IDLE;
        end else if (pstb_take) begin
            if (chip_sel) begin
                ctl_d.st   = ACC_READ;
                ctl_d.base = addr;
                ctl_d.cnt  = '0;
            end else begin
                ctl_d.st = ACC_IDLE;
            end
        end else if (cstb_take) begin
            if (chip_sel) begin
                ctl_d.base = addr;
                ctl_d.cnt  = '0;
                if (wr_req) begin
                    mem_we    = 1'b1;
                    mem_waddr = addr;
                    ctl_d.st  = ACC_WRITE;
                end else begin
                    ctl_d.st = ACC_READ;
                end
            end else begin
                ctl_d.st = ACC_IDLE;
            end
        end else if (ctl_q.st != ACC_IDLE) begin
            ctl_d.cnt = step_cnt;
            mem_waddr = cont_addr;
            if (wr_req) begin
                mem_we   = 1'b1;
                ctl_d.st = ACC_WRITE;
            end else begin
                ctl_d.st = ACC_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ACC_IDLE, base: '0, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign st_q = ctl_q.st;

    // ---------------- storage ----------------
    sram_core #(
        .AW     (AW),
        .NB     (NB),
        .BYTE_W (BYTE_W)
    ) u_core (
        .clk   (clk),
        .we    (mem_we),
        .wmask (wmask),
        .waddr (mem_waddr),
        .wdata (dq_i),
        .raddr (cur_addr),
        .rdata (rdata)
    );

    // ---------------- bus drive ----------------
    assign dq_oe = !blocked && (st_q == ACC_READ) && !out_en_n && !wr_req;
    assign dq_o  = dq_oe ? rdata : '0;

endmodule

// File: rtl/sync_burst_sram_chk.sv
`timescale 1ns/1ps
module sync_burst_sram_chk
    import sbsram_pkg::*;
#(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pstb_n,
    input logic          cstb_n,
    input logic          en1_n,
    input logic          en2,
    input logic          en3_n,
    input logic          wr_all_n,
    input logic          wr_byte_n,
    input logic [NB-1:0] byte_sel_n,
    input logic          out_en_n,
    input logic          dq_oe,
    input logic          asleep,
    input logic          recovering,
    input logic          mem_we,
    input acc_e          st_q
);

    logic sel_ok;
    logic any_wr;
    logic blk;

    assign sel_ok = !en1_n && en2 && !en3_n;
    assign any_wr = !wr_all_n || (!wr_byte_n && !(&byte_sel_n));
    assign blk    = asleep || recovering;

    p_oe_gates_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !out_en_n);

    p_hiz_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |-> !dq_oe);

    p_hiz_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ACC_WRITE) |-> !dq_oe);

    p_ctl_write_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk && !cstb_n && pstb_n && sel_ok && any_wr) |-> mem_we);

    p_pstb_defers_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk && !pstb_n && !en1_n) |-> !mem_we);

    p_pstb_opens_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk && !pstb_n && !en1_n && sel_ok) |=> (st_q == ACC_READ));

    p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk && !pstb_n && !en1_n && !sel_ok) |=> (st_q == ACC_IDLE));

    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        blk |-> (!mem_we && !dq_oe));

    p_sleep_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> (st_q == ACC_IDLE));

    p_no_access_in_recovery_r12: assert property (@(posedge clk) disable iff (!rst_n)
        recovering |-> !((!pstb_n && !en1_n) || (!cstb_n && sel_ok)));

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.NB(NB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pstb_n     (pstb_n),
    .cstb_n     (cstb_n),
    .en1_n      (en1_n),
    .en2        (en2),
    .en3_n      (en3_n),
    .wr_all_n   (wr_all_n),
    .wr_byte_n  (wr_byte_n),
    .byte_sel_n (byte_sel_n),
    .out_en_n   (out_en_n),
    .dq_oe      (dq_oe),
    .asleep     (asleep),
    .recovering (recovering),
    .mem_we     (mem_we),
    .st_q       (st_q)
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int DW = NB * 8;
    localparam int RC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          pstb_n = 1'b1, cstb_n = 1'b1, step_n = 1'b1;
    logic          en1_n = 1'b1, en2 = 1'b0, en3_n = 1'b1;
    logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [NB-1:0] byte_sel_n = '1;
    logic          out_en_n = 1'b1, burst_linear = 1'b1, sleep_req = 1'b0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    always #10 clk = ~clk;

    sync_burst_sram #(.AW(AW), .NB(NB), .BURST_BITS(2), .RECOV_CYC(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
        .step_n(step_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
        .out_en_n(out_en_n), .burst_linear(burst_linear), .sleep_req(sleep_req),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string req    = "R10";

    // ---------------- behavioural reference ----------------
    logic [DW-1:0] mm [256];
    int m_st = 0, m_base = 0, m_cnt = 0, m_s1 = 0, m_s2 = 0, m_rc = 0;

    function automatic logic [DW-1:0] dval(int a);
        return 32'hC0DE_0000 + DW'(a);
    endfunction

    function automatic logic [NB-1:0] bmask();
        if (!wr_all_n) return '1;
        if (!wr_byte_n) return ~byte_sel_n;
        return '0;
    endfunction

    function automatic int cur_a();
        int s = m_base & 3;
        int o = burst_linear ? ((s + m_cnt) % 4) : ((s ^ m_cnt) & 3);
        return (m_base & ~3) | o;
    endfunction

    task automatic check1(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic mwrite(int a, logic [NB-1:0] wm);
        for (int b = 0; b < NB; b++)
            if (wm[b]) mm[a][b*8 +: 8] = dq_i[b*8 +: 8];
    endtask

    task automatic compare();
        bit blk = (m_s2 != 0) || (m_rc != 0);
        bit eoe = !blk && (m_st == 1) && !out_en_n && (bmask() == '0);
        check1(req, {31'b0, dq_oe}, {31'b0, eoe});
        if (eoe && !$isunknown(mm[cur_a()]))
            check1(req, dq_o, mm[cur_a()]);
    endtask

    task automatic model_edge();
        bit blk = (m_s2 != 0) || (m_rc != 0);
        bit cs  = !en1_n && en2 && !en3_n;
        logic [NB-1:0] wm = bmask();
        if (blk) m_st = 0;
        else if (!pstb_n && !en1_n) begin
            if (cs) begin m_base = int'(addr); m_cnt = 0; m_st = 1; end
            else m_st = 0;
        end else if (pstb_n && !cstb_n) begin
            if (cs) begin
                m_base = int'(addr); m_cnt = 0;
                if (wm != '0) begin mwrite(int'(addr), wm); m_st = 2; end
                else m_st = 1;
            end else m_st = 0;
        end else if (m_st != 0) begin
            if (!step_n) m_cnt = (m_cnt + 1) % 4;
            if (wm != '0) begin mwrite(cur_a(), wm); m_st = 2; end
            else m_st = 1;
        end
        if (m_s2 != 0 && m_s1 == 0) m_rc = RC;
        else if (m_rc != 0) m_rc--;
        m_s2 = m_s1;
        m_s1 = int'(sleep_req);
    endtask

    // One clock: compare just before the rising edge, then advance the model
    task automatic cyc();
        #8;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_in();
        pstb_n = 1'b1; cstb_n = 1'b1; step_n = 1'b1;
        en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b1 ^ 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = '1; out_en_n = 1'b0;
    endtask

    task automatic ctl_write(int a, logic [DW-1:0] d);
        idle_in(); cstb_n = 1'b0; addr = AW'(a); wr_all_n = 1'b0; dq_i = d;
        cyc();
    endtask

    task automatic ctl_read(int a);
        idle_in(); cstb_n = 1'b0; addr = AW'(a);
        cyc();
    endtask

    task automatic idle_chk(string tag, logic [DW-1:0] exp);
        idle_in(); #1;
        check1(tag, {31'b0, dq_oe}, 32'd1);
        check1(tag, dq_o, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_in(); out_en_n = 1'b1;
        rst_n = 1'b1;
        #1 check1("R10 reset", {31'b0, dq_oe}, 32'd0);

        // R4 / R6: controller-strobe writes, bus released during each
        req = "R4";
        for (int a = 16; a < 20; a++) begin
            ctl_write(a, dval(a));
        end
        for (int a = 64; a < 68; a++) ctl_write(a, dval(a));
        for (int a = 80; a < 84; a++) ctl_write(a, dval(a));
        idle_in(); #1 check1("R6", {31'b0, dq_oe}, 32'd0);

        // R1: flow-through read via each strobe
        req = "R1";
        ctl_read(17);
        idle_chk("R1", dval(17));
        idle_in(); pstb_n = 1'b0; addr = 8'd18; cyc();
        idle_chk("R1", dval(18));

        // R7: output enable high releases the bus
        req = "R7";
        out_en_n = 1'b1; #1 check1("R7", {31'b0, dq_oe}, 32'd0);
        cyc();

        // R3: processor strobe ignores write controls and step at its edge
        req = "R3";
        ctl_write(32, 32'h0000_1234);
        idle_in(); pstb_n = 1'b0; addr = 8'd32; wr_all_n = 1'b0; step_n = 1'b0;
        dq_i = 32'hDEAD_BEEF; cyc();
        idle_chk("R3", 32'h0000_1234);
        idle_in(); wr_all_n = 1'b0; dq_i = 32'h5555_AAAA; cyc();
        ctl_read(32);
        idle_chk("R3", 32'h5555_AAAA);

        // R5: byte selects and the no-byte-selected read
        req = "R5";
        ctl_write(48, 32'h0);
        idle_in(); cstb_n = 1'b0; addr = 8'd48; wr_byte_n = 1'b0;
        byte_sel_n = 4'b1010; dq_i = 32'hAABB_CCDD; cyc();
        idle_in(); cstb_n = 1'b0; addr = 8'd48; wr_byte_n = 1'b0; cyc();
        idle_chk("R5", 32'h00BB_00DD);

        // R8: linear then interleaved bursts from offset 1
        req = "R8";
        burst_linear = 1'b1;
        ctl_read(65);
        idle_chk("R8", dval(65));
        for (int k = 1; k < 4; k++) begin
            idle_in(); step_n = 1'b0; cyc();
            idle_chk("R8", dval(64 + ((1 + k) % 4)));
        end
        burst_linear = 1'b0;
        ctl_read(65);
        for (int k = 1; k < 4; k++) begin
            idle_in(); step_n = 1'b0; cyc();
            idle_chk("R8", dval(64 + (1 ^ k)));
        end
        // R8: linear burst write, then read back
        burst_linear = 1'b1;
        ctl_write(82, 32'h0000_0A00);
        for (int k = 1; k < 4; k++) begin
            idle_in(); step_n = 1'b0; wr_all_n = 1'b0; dq_i = 32'h0000_0A00 + DW'(k); cyc();
        end
        ctl_read(82);
        idle_chk("R8", 32'h0000_0A00);
        for (int k = 1; k < 4; k++) begin
            idle_in(); step_n = 1'b0; cyc();
            idle_chk("R8", 32'h0000_0A00 + DW'(k));
        end

        // R9: hold address, then a continuing write
        req = "R9";
        ctl_read(19);
        idle_in(); cyc(); cyc();
        idle_chk("R9", dval(19));
        idle_in(); wr_all_n = 1'b0; dq_i = 32'h0909_0909; cyc();
        ctl_read(19);
        idle_chk("R9", 32'h0909_0909);

        // R2: processor strobe ignored with primary enable high
        req = "R2";
        ctl_read(16);
        idle_in(); en1_n = 1'b1; pstb_n = 1'b0; addr = 8'd18; cyc();
        idle_chk("R2", dval(16));

        // R4: controller strobe ignored while processor strobe is low
        req = "R4";
        idle_in(); en1_n = 1'b1; pstb_n = 1'b0; cstb_n = 1'b0; addr = 8'd18; cyc();
        idle_chk("R4", dval(16));

        // R10: deselect through a disabled enable
        req = "R10";
        idle_in(); cstb_n = 1'b0; en2 = 1'b0; addr = 8'd17; cyc();
        idle_in(); step_n = 1'b0; #1 check1("R10", {31'b0, dq_oe}, 32'd0);
        cyc();
        idle_in(); #1 check1("R10", {31'b0, dq_oe}, 32'd0);
        cyc();

        // R11: sleep entry, refused writes, contents kept
        req = "R11";
        ctl_read(16);
        idle_in(); sleep_req = 1'b1; cyc();
        #1 check1("R11", {31'b0, dq_oe}, 32'd1);
        cyc();
        #1 check1("R11", {31'b0, dq_oe}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            idle_in(); cstb_n = 1'b0; addr = 8'd16; wr_all_n = 1'b0; dq_i = 32'hBAD0_BAD0; cyc();
        end
        // R12: release, wait out synchroniser plus recovery, access at first free edge
        req = "R12";
        idle_in(); sleep_req = 1'b0;
        repeat (2 + RC) cyc();
        ctl_read(16);
        idle_chk("R12", dval(16));
        idle_chk("R11", dval(16));

        idle_in(); cyc();
        finish_run();
    end

endmodule